// File: doc/BRIEF.md
# Performance Request Register and Target Resolver

This block stores the performance request word that system software writes: a minimum, a maximum, a desired level and an energy/performance preference, each one byte wide. From that word, three capability levels (highest, lowest, most efficient) and a target proposed by an autonomous selection engine, it resolves one byte-wide operating target on every cycle.

A zero desired level hands the choice to the autonomous input. A non-zero desired level is an explicit target and overrides that input. The result is then bounded by the software minimum and by an effective maximum. That effective maximum is never allowed below the most-efficient level. A read port returns either the request word exactly as stored or a capability word whose upper half is zero.

Top module: `perf_req_ctrl`

## Requirements
- R1: After reset, with no write yet, the request word reads as preference 0, desired 0, maximum equal to `cap_highest_i` and minimum equal to `cap_lowest_i`. Until the first write, the minimum and maximum defaults follow later changes of those inputs.
- R2: A write with `wr_en_i` high stores `wr_data_i` at the clock edge. From the next cycle a read with `rd_sel_i` low returns it unchanged in bits 31:0 with bits 63:32 zero. This holds even for fields that the resolver overrides. Field layout: minimum 7:0, maximum 15:8, desired 23:16, preference 31:24.
- R3: With desired equal to 0, `target_o` is `auto_target_i` bounded to at least the minimum and at most the effective maximum.
- R4: With desired non-zero, the desired value is first bounded into [`cap_lowest_i`, `cap_highest_i`] and then bounded by the minimum and the effective maximum. `auto_target_i` has no effect on `target_o` in this case.
- R5: The effective maximum is the larger of the stored maximum and `cap_effic_i`.
- R6: When the minimum exceeds the effective maximum, `target_o` equals the minimum. `target_o` is never below the minimum.
- R7: With `rd_sel_i` high, `rd_data_o` returns the capability word: `cap_highest_i` in 7:0, zero in 15:8, `cap_effic_i` in 23:16, `cap_lowest_i` in 31:24 and zero in 63:32.
- R8: `pref_o` presents the stored preference field, where 0 favours performance and 0xFF favours efficiency. The preference has no influence on `target_o`.
- R9: With `wr_en_i` low, `wr_data_i` is ignored and the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the request word |
| wr_data_i | input | 32 | Request word to store |
| rd_sel_i | input | 1 | 0 selects the request word, 1 selects the capability word |
| rd_data_o | output | 64 | Read data |
| cap_highest_i | input | 8 | Highest performance capability |
| cap_lowest_i | input | 8 | Lowest performance capability |
| cap_effic_i | input | 8 | Most efficient performance level |
| auto_target_i | input | 8 | Target proposed by autonomous selection |
| target_o | output | 8 | Resolved operating target |
| pref_o | output | 8 | Stored energy/performance preference |

## Verification
A write to the request word and a change of the autonomous target can land in the same cycle. The bench drives both together. It expects `target_o` in that cycle to combine the old word with the new autonomous value, and from the next cycle to combine the new word with it. A read issued in the same cycle as a write is expected to return the previous word. The reference model updates its copy only after the clock edge, so either kind of mix-up shows up as a mismatch.

// File: rtl/perf_req_pkg.sv
package perf_req_pkg;
  localparam int unsigned PERF_W = 8;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned REQ_W = NUM_FIELDS * PERF_W;
  localparam int unsigned RD_W = 2 * REQ_W;

  typedef logic [PERF_W-1:0] perf_t;

  typedef struct packed {
    perf_t pref;
    perf_t desired;
    perf_t max_lvl;
    perf_t min_lvl;
  } req_word_t;

  // upper bound applied first, lower bound last so the lower one wins
  function automatic perf_t bound(input perf_t v, input perf_t lo, input perf_t hi);
    perf_t t;
    t = (v > hi) ? hi : v;
    return (t < lo) ? lo : t;
  endfunction
endpackage

// File: rtl/perf_req_regs.sv
module perf_req_regs
  import perf_req_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  req_word_t wr_word_i,
  input  perf_t     dflt_min_i,
  input  perf_t     dflt_max_i,
  output req_word_t req_o
);
  req_word_t word_q;
  logic      min_dflt_q, max_dflt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      min_dflt_q <= 1'b1;
      max_dflt_q <= 1'b1;
    end else if (wr_en_i) begin
      word_q     <= wr_word_i;
      min_dflt_q <= 1'b0;
      max_dflt_q <= 1'b0;
    end
  end

  // defaults track the capability inputs until software writes
  always_comb begin
    req_o = word_q;
    if (min_dflt_q) req_o.min_lvl = dflt_min_i;
    if (max_dflt_q) req_o.max_lvl = dflt_max_i;
  end
endmodule

// File: rtl/perf_resolver.sv
module perf_resolver
  import perf_req_pkg::*;
(
  input  req_word_t req_i,
  input  perf_t     cap_highest_i,
  input  perf_t     cap_lowest_i,
  input  perf_t     cap_effic_i,
  input  perf_t     auto_target_i,
  output perf_t     eff_max_o,
  output perf_t     target_o
);
  perf_t sel;

  assign eff_max_o = (req_i.max_lvl < cap_effic_i) ? cap_effic_i : req_i.max_lvl;

  always_comb begin
    if (req_i.desired == '0) sel = auto_target_i;
    else                     sel = bound(req_i.desired, cap_lowest_i, cap_highest_i);
  end

  assign target_o = bound(sel, req_i.min_lvl, eff_max_o);
endmodule

// File: rtl/perf_req_ctrl.sv
module perf_req_ctrl
  import perf_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REQ_W-1:0]  wr_data_i,
  input  logic              rd_sel_i,
  output logic [RD_W-1:0]   rd_data_o,
  input  logic [PERF_W-1:0] cap_highest_i,
  input  logic [PERF_W-1:0] cap_lowest_i,
  input  logic [PERF_W-1:0] cap_effic_i,
  input  logic [PERF_W-1:0] auto_target_i,
  output logic [PERF_W-1:0] target_o,
  output logic [PERF_W-1:0] pref_o
);
  req_word_t         req;
  perf_t             eff_max;
  logic [REQ_W-1:0]  cap_word;

  perf_req_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_word_i  (req_word_t'(wr_data_i)),
    .dflt_min_i (cap_lowest_i),
    .dflt_max_i (cap_highest_i),
    .req_o      (req)
  );

  perf_resolver u_res (
    .req_i         (req),
    .cap_highest_i (cap_highest_i),
    .cap_lowest_i  (cap_lowest_i),
    .cap_effic_i   (cap_effic_i),
    .auto_target_i (auto_target_i),
    .eff_max_o     (eff_max),
    .target_o      (target_o)
  );

  assign cap_word  = {cap_lowest_i, cap_effic_i, {PERF_W{1'b0}}, cap_highest_i};
  assign rd_data_o = {{(RD_W-REQ_W){1'b0}}, (rd_sel_i ? cap_word : REQ_W'(req))};
  assign pref_o    = req.pref;
endmodule

// File: rtl/perf_req_chk.sv
module perf_req_chk
  import perf_req_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REQ_W-1:0]  wr_data_i,
  input logic              rd_sel_i,
  input logic [RD_W-1:0]   rd_data_o,
  input logic [PERF_W-1:0] cap_effic_i,
  input logic [PERF_W-1:0] auto_target_i,
  input logic [PERF_W-1:0] target_o,
  input req_word_t         req,
  input perf_t             eff_max
);
  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_sel_i || rd_data_o[REQ_W-1:0] == $past(wr_data_i))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && $past(wr_en_i)) |=> $stable(req)); // R9

  AST_AUTO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req.desired == '0 && auto_target_i >= req.min_lvl && auto_target_i <= eff_max)
      |-> target_o == auto_target_i); // R3

  AST_EFF_MAX_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req.min_lvl <= cap_effic_i) |-> target_o <= eff_max && eff_max >= cap_effic_i); // R5

  AST_MIN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_o >= req.min_lvl); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RD_W-1:REQ_W] == '0); // R7
endmodule

bind perf_req_ctrl perf_req_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_sel_i      (rd_sel_i),
  .rd_data_o     (rd_data_o),
  .cap_effic_i   (cap_effic_i),
  .auto_target_i (auto_target_i),
  .target_o      (target_o),
  .req           (req),
  .eff_max       (eff_max)
);

// File: tb/tb_perf_req_ctrl.sv
module tb_perf_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [63:0] rd_data;
  logic [7:0]  cap_hi = 8'd200, cap_lo = 8'd10, cap_ef = 8'd40, auto_t = 8'd0;
  logic [7:0]  target, pref;

  int errors = 0, checks = 0;
  int m_min = 0, m_max = 0, m_des = 0, m_pref = 0;
  bit m_dflt = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_req_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .cap_highest_i(cap_hi),
    .cap_lowest_i(cap_lo), .cap_effic_i(cap_ef), .auto_target_i(auto_t),
    .target_o(target), .pref_o(pref)
  );

  function automatic int cur_min(); return m_dflt ? int'(cap_lo) : m_min; endfunction
  function automatic int cur_max(); return m_dflt ? int'(cap_hi) : m_max; endfunction

  function automatic logic [63:0] exp_rd();
    if (rd_sel) return {32'h0, cap_lo, cap_ef, 8'h00, cap_hi};
    return {32'h0, 8'(m_pref), 8'(m_des), 8'(cur_max()), 8'(cur_min())};
  endfunction

  function automatic int exp_tgt();
    int mn, emx, sel, t;
    mn  = cur_min();
    emx = (cur_max() < int'(cap_ef)) ? int'(cap_ef) : cur_max();
    if (m_des == 0) sel = int'(auto_t);
    else if (m_des < int'(cap_lo)) sel = int'(cap_lo);
    else if (m_des > int'(cap_hi)) sel = int'(cap_hi);
    else sel = m_des;
    t = (sel > emx) ? emx : sel;
    if (t < mn) t = mn;
    return t;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive, compare in mid-cycle, then advance one clock and update the model
  task automatic step(input bit we, input logic [31:0] wd, input bit rs,
                      input logic [7:0] au, input string tag);
    wr_en = we; wr_data = wd; rd_sel = rs; auto_t = au;
    #1;
    chk({tag, " rd"}, rd_data, exp_rd());
    chk({tag, " target"}, {56'h0, target}, 64'(exp_tgt()));
    chk({tag, " pref"}, {56'h0, pref}, 64'(m_pref));
    @(posedge clk);
    if (we) begin
      m_min = int'(wd[7:0]); m_max = int'(wd[15:8]);
      m_des = int'(wd[23:16]); m_pref = int'(wd[31:24]); m_dflt = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] w(input int pf, input int ds, input int mx, input int mn);
    return {8'(pf), 8'(ds), 8'(mx), 8'(mn)};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, '0, 0, 8'd100, "R1 reset word");
    step(0, '0, 1, 8'd100, "R7 cap word");
    cap_lo = 8'd12; cap_hi = 8'd190;
    step(0, '0, 0, 8'd100, "R1 defaults track caps");
    cap_lo = 8'd10; cap_hi = 8'd200;
    step(0, '0, 0, 8'd5,   "R3 auto below min");
    step(0, '0, 0, 8'd250, "R3 auto above max");
    step(1, w(8'h80, 0, 150, 20), 0, 8'd77, "R3 auto mid, write same cycle");
    step(0, '0, 0, 8'd77,  "R2 readback");
    step(0, '0, 0, 8'd160, "R3 auto over stored max");
    step(0, 32'hDEAD_BEEF, 0, 8'd60, "R9 write disabled");
    step(0, '0, 0, 8'd60,  "R9 word unchanged");
    step(1, w(8'hFF, 90, 150, 20), 0, 8'd60, "R8 pref write");
    step(0, '0, 0, 8'd3,   "R4 explicit 90 ignores auto");
    step(0, '0, 0, 8'd250, "R8 pref no effect on target");
    step(1, w(0, 250, 255, 5), 0, 8'd1, "R4 write high desired");
    step(0, '0, 0, 8'd1,   "R4 desired over highest");
    step(1, w(0, 3, 255, 5), 0, 8'd1, "R4 write low desired");
    step(0, '0, 0, 8'd1,   "R4 desired under lowest");
    step(1, w(0, 0, 30, 5), 0, 8'd100, "R5 write max below efficient");
    step(0, '0, 0, 8'd100, "R5 effective max raised");
    step(0, '0, 0, 8'd35,  "R5 auto inside raised bound");
    step(1, w(0, 0, 60, 120), 0, 8'd80, "R6 write crossed bounds");
    step(0, '0, 0, 8'd80,  "R6 min wins");
    step(0, '0, 0, 8'd200, "R6 min wins high auto");
    cap_lo = 8'd1; cap_hi = 8'd255;
    step(0, '0, 0, 8'd80,  "R1 no tracking after write");
    step(0, '0, 1, 8'd80,  "R7 cap word after change");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule